// File: doc/BRIEF.md
# Coherent Data Cache with Allocation Gating

This block is a small direct-mapped data cache controller for one processing element. Each line holds a tag, one data word and a four-state MESI coherence state. Requests from the local port carry a two-bit memory attribute. The attribute selects one of three handlings: write-back with read and write allocation, write-back without allocation, or uncached. Misses and uncached accesses go to a simple memory port that completes on an acknowledge. Ownership changes are announced to a peer cache through an invalidate broadcast port. A snoop port lets the peer query or invalidate lines held here.

The enable input only gates allocation. With enable low, no request from the local port installs a new line, and an allocating request is handled as a non-allocating one. Lines that are already resident are still looked up, read and written exactly as with enable high. Snoops are still answered, so the cache stays coherent while it is being drained or shut down. Enable is captured when a request is accepted, so a change affects only later requests.

Top module: `coh_dcache`

## Requirements
- R1: After a synchronous reset, every line is Invalid, `req_ready` and `snp_ready` are high, and `mem_valid`, `inv_valid` and `rsp_valid` are low.
- R2: Attribute code 0 (and unused code 3) is uncached. Such a request does no lookup and performs exactly one memory read or write. A read returns the memory word. A resident line keeps its state and data.
- R3: A read miss with attribute code 2 and enable high fills the line with one memory read and returns the fill word. The line becomes Exclusive when `mem_shared` is low at the acknowledge and Shared when it is high.
- R4: A write miss with attribute code 2 and enable high sends one invalidate broadcast and installs the line Modified with the write word. It makes no memory access, because a line is a single word.
- R5: A miss with attribute code 1, or with code 2 while enable is low, never allocates. A read does one memory read and returns its word. A write does one memory write. The line stays Invalid.
- R6: A read hit on attribute code 1 or 2 returns the cached word with no memory access, whatever the enable level.
- R7: A write hit on an Exclusive line moves it to Modified with no broadcast. A write hit on a Modified line keeps it Modified. A write hit on a Shared line first sends one invalidate broadcast, then moves it to Modified. All three update the data whatever the enable level.
- R8: An allocating miss whose index holds a Modified line with another tag first writes the old word back to the old address.
- R9: A read snoop that hits a Modified line returns the word, writes it back and leaves the line Shared. A hit on an Exclusive line moves it to Shared. `snp_hit` and `snp_dirty` report the line found.
- R10: An invalidating snoop leaves a hit line Invalid. A Modified line is written back and its word supplied first. A clean line is dropped with no memory access.
- R11: The enable level is sampled when a request is accepted. Changing it while that request is in flight does not change whether it allocates.
- R12: Snoops are answered the same way with enable low as with enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Allocation enable, sampled at request acceptance |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 2 | 0 uncached, 1 write-back no-allocate, 2 write-back allocate, 3 uncached |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word, valid with rsp_valid on reads |
| mem_valid | output | 1 | Memory access pending, held until mem_ack |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | DATA_W | Memory read word, valid with mem_ack |
| mem_shared | input | 1 | Filled word is also held by the peer, valid with mem_ack |
| inv_valid | output | 1 | Invalidate broadcast pending, held until inv_ack |
| inv_addr | output | ADDR_W | Address to invalidate in the peer |
| inv_ack | input | 1 | Broadcast completes this cycle |
| snp_valid | input | 1 | Snoop request present |
| snp_inv | input | 1 | 1 = invalidating snoop, 0 = read snoop |
| snp_addr | input | ADDR_W | Snoop address |
| snp_ready | output | 1 | Snoop accepted this cycle when valid |
| snp_done | output | 1 | One-cycle snoop completion pulse |
| snp_hit | output | 1 | Snooped line was resident |
| snp_dirty | output | 1 | Snooped line was Modified |
| snp_data | output | DATA_W | Word of the snooped line |

## Verification
The bench sweeps every pairing of enable level, attribute code, read or write, and starting line state (Invalid, Exclusive, Modified). After each request it probes the line with a read snoop. This separates a lookup from a bypass, an allocation from a pass-through, and a silent upgrade from a broadcast one. The memory-access and broadcast counts for each request separate a fill from a forward and a hit from a miss. Directed patterns then cover a Shared fill followed by a write, a conflict eviction of a dirty victim, and both snoop kinds on clean and dirty lines. Two further patterns flip the enable level while a fill is still in flight, which shows whether the level is taken at acceptance or later.

// File: rtl/coh_dcache_pkg.sv
package coh_dcache_pkg;
  typedef enum logic [1:0] {ST_I, ST_S, ST_E, ST_M} mesi_t;

  localparam logic [1:0] ATTR_NC  = 2'd0;
  localparam logic [1:0] ATTR_NA  = 2'd1;
  localparam logic [1:0] ATTR_RWA = 2'd2;

  typedef enum logic [2:0] {ACT_MEM, ACT_DONE, ACT_INV, ACT_FILL, ACT_WB} act_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_dcache_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output mesi_t             rd_state,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  mesi_t             wr_state
);
  localparam int LINES = 1 << IDX_W;

  // tag and data carry no reset so they map onto distributed RAM
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  mesi_t             state_q  [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) state_q[i] <= ST_I;
    end else if (we) begin
      state_q[wr_idx] <= wr_state;
    end
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];
  assign rd_state = state_q[rd_idx];
endmodule

// File: rtl/coh_alloc_policy.sv
module coh_alloc_policy
  import coh_dcache_pkg::*;
(
  input  logic [1:0] attr,
  input  logic       en,
  input  logic       write,
  input  logic       hit,
  input  mesi_t      line_st,
  output act_t       act
);
  logic cacheable;
  logic alloc;

  always_comb begin
    cacheable = (attr == ATTR_NA) || (attr == ATTR_RWA);
    // with enable low an allocating attribute degrades to no-allocate
    alloc = en && (attr == ATTR_RWA);
    if (!cacheable)                 act = ACT_MEM;
    else if (hit)                   act = (write && line_st == ST_S) ? ACT_INV : ACT_DONE;
    else if (!alloc)                act = ACT_MEM;
    else if (line_st == ST_M)       act = ACT_WB;
    else if (write)                 act = ACT_INV;
    else                            act = ACT_FILL;
  end
endmodule

// File: rtl/coh_dcache.sv
module coh_dcache
  import coh_dcache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_attr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_shared,
  output logic              inv_valid,
  output logic [ADDR_W-1:0] inv_addr,
  input  logic              inv_ack,
  input  logic              snp_valid,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ready,
  output logic              snp_done,
  output logic              snp_hit,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_MEM, S_WB, S_FILL, S_INV, S_SNP, S_SNWB} fsm_t;

  fsm_t              st;
  logic              r_write, r_en, s_inv;
  logic [1:0]        r_attr;
  logic [ADDR_W-1:0] r_addr, s_addr;
  logic [DATA_W-1:0] r_wdata;

  logic              snp_ctx;
  logic [IDX_W-1:0]  rd_idx;
  logic [TAG_W-1:0]  rd_tag, lk_tag;
  logic [DATA_W-1:0] rd_data;
  mesi_t             rd_state;
  logic              lk_hit;
  act_t              act;

  logic              st_we;
  logic [IDX_W-1:0]  st_idx;
  logic [TAG_W-1:0]  st_tag;
  logic [DATA_W-1:0] st_data;
  mesi_t             st_state;

  assign snp_ctx   = (st == S_SNP) || (st == S_SNWB);
  assign rd_idx    = snp_ctx ? s_addr[IDX_W-1:0] : r_addr[IDX_W-1:0];
  assign lk_tag    = snp_ctx ? s_addr[ADDR_W-1:IDX_W] : r_addr[ADDR_W-1:IDX_W];
  assign lk_hit    = (rd_state != ST_I) && (rd_tag == lk_tag);
  assign req_ready = (st == S_IDLE) && !snp_valid;
  assign snp_ready = (st == S_IDLE);

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_data(rd_data), .rd_state(rd_state),
    .we(st_we), .wr_idx(st_idx), .wr_tag(st_tag), .wr_data(st_data), .wr_state(st_state)
  );

  coh_alloc_policy u_policy (
    .attr(r_attr), .en(r_en), .write(r_write), .hit(lk_hit), .line_st(rd_state), .act(act)
  );

  // line store update for every state that changes a line
  always_comb begin
    st_we    = 1'b0;
    st_idx   = r_addr[IDX_W-1:0];
    st_tag   = r_addr[ADDR_W-1:IDX_W];
    st_data  = r_wdata;
    st_state = ST_M;
    unique case (st)
      S_LOOK: st_we = (act == ACT_DONE) && r_write;
      S_FILL: begin
        st_we    = mem_ack;
        st_data  = mem_rdata;
        st_state = mem_shared ? ST_S : ST_E;
      end
      S_INV:  st_we = inv_ack;
      S_SNP, S_SNWB: begin
        st_we    = (st == S_SNP) ? (lk_hit && rd_state != ST_M) : mem_ack;
        st_idx   = s_addr[IDX_W-1:0];
        st_tag   = rd_tag;
        st_data  = rd_data;
        st_state = s_inv ? ST_I : ST_S;
      end
      default: st_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      r_write   <= 1'b0;
      r_en      <= 1'b0;
      r_attr    <= ATTR_NC;
      r_addr    <= '0;
      r_wdata   <= '0;
      s_inv     <= 1'b0;
      s_addr    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      inv_valid <= 1'b0;
      inv_addr  <= '0;
      snp_done  <= 1'b0;
      snp_hit   <= 1'b0;
      snp_dirty <= 1'b0;
      snp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      snp_done  <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (snp_valid) begin
            s_addr <= snp_addr;
            s_inv  <= snp_inv;
            st     <= S_SNP;
          end else if (req_valid) begin
            r_write <= req_write;
            r_attr  <= req_attr;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_en    <= cache_en;
            st      <= S_LOOK;
          end
        end
        S_LOOK: begin
          unique case (act)
            ACT_MEM: begin
              mem_valid <= 1'b1;
              mem_write <= r_write;
              mem_addr  <= r_addr;
              mem_wdata <= r_wdata;
              st        <= S_MEM;
            end
            ACT_DONE: begin
              rsp_valid <= 1'b1;
              rsp_rdata <= rd_data;
              st        <= S_IDLE;
            end
            ACT_INV: begin
              inv_valid <= 1'b1;
              inv_addr  <= r_addr;
              st        <= S_INV;
            end
            ACT_FILL: begin
              mem_valid <= 1'b1;
              mem_write <= 1'b0;
              mem_addr  <= r_addr;
              st        <= S_FILL;
            end
            default: begin
              mem_valid <= 1'b1;
              mem_write <= 1'b1;
              mem_addr  <= {rd_tag, r_addr[IDX_W-1:0]};
              mem_wdata <= rd_data;
              st        <= S_WB;
            end
          endcase
        end
        S_MEM, S_FILL: if (mem_ack) begin
          mem_valid <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rdata;
          st        <= S_IDLE;
        end
        S_WB: if (mem_ack) begin
          if (r_write) begin
            mem_valid <= 1'b0;
            inv_valid <= 1'b1;
            inv_addr  <= r_addr;
            st        <= S_INV;
          end else begin
            mem_write <= 1'b0;
            mem_addr  <= r_addr;
            st        <= S_FILL;
          end
        end
        S_INV: if (inv_ack) begin
          inv_valid <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= r_wdata;
          st        <= S_IDLE;
        end
        S_SNP: begin
          if (lk_hit && rd_state == ST_M) begin
            mem_valid <= 1'b1;
            mem_write <= 1'b1;
            mem_addr  <= s_addr;
            mem_wdata <= rd_data;
            st        <= S_SNWB;
          end else begin
            snp_done  <= 1'b1;
            snp_hit   <= lk_hit;
            snp_dirty <= 1'b0;
            snp_data  <= rd_data;
            st        <= S_IDLE;
          end
        end
        default: if (mem_ack) begin
          mem_valid <= 1'b0;
          snp_done  <= 1'b1;
          snp_hit   <= 1'b1;
          snp_dirty <= 1'b1;
          snp_data  <= rd_data;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  logic look_cacheable;
  assign look_cacheable = (r_attr == ATTR_NA) || (r_attr == ATTR_RWA);

  AST_FILL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (st == S_FILL) |-> (r_en && r_attr == ATTR_RWA)); // R5
  AST_NC_SKIPS_CACHE: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && !look_cacheable) |=> (mem_valid && !inv_valid)); // R2
  AST_SHARED_WR_INV: assert property (@(posedge clk) disable iff (rst)
    (st == S_LOOK && look_cacheable && r_write && lk_hit && rd_state == ST_S) |=> inv_valid); // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R3
  AST_SNOOP_DIRTY_WB: assert property (@(posedge clk) disable iff (rst)
    (st == S_SNP && lk_hit && rd_state == ST_M) |=> (mem_valid && mem_write)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R6
endmodule

// File: tb/sim_coh_dcache.sv
module sim_coh_dcache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cache_en = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_attr = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0, mem_shared = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          inv_valid, inv_ack = 1'b0;
  logic [AW-1:0] inv_addr;
  logic          snp_valid = 1'b0, snp_inv = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_ready, snp_done, snp_hit, snp_dirty;
  logic [DW-1:0] snp_data;

  logic          shr = 1'b0;
  logic [DW-1:0] bmem [256];
  int            mrd = 0, mwr = 0, ninv = 0;
  int            errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_dcache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2)) u0 (
    .clk(clk), .rst(rst), .cache_en(cache_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_attr(req_attr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_shared(mem_shared),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr), .snp_ready(snp_ready),
    .snp_done(snp_done), .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_data(snp_data)
  );

  // memory and peer responders, acting between clock edges
  always @(negedge clk) begin
    if (mem_valid && !mem_ack) begin
      mem_ack = 1'b1;
      mem_shared = shr;
      if (mem_write) begin bmem[mem_addr] = mem_wdata; mwr++; end
      else begin mem_rdata = bmem[mem_addr]; mrd++; end
    end else mem_ack = 1'b0;
    if (inv_valid && !inv_ack) begin inv_ack = 1'b1; ninv++; end
    else inv_ack = 1'b0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_req(input logic w, input logic [1:0] at, input logic [AW-1:0] ad,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_attr = at; req_addr = ad; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  task automatic probe(input logic inv, input logic [AW-1:0] ad,
                       output logic h, output logic d, output logic [DW-1:0] dat);
    @(negedge clk);
    snp_valid = 1'b1; snp_inv = inv; snp_addr = ad;
    while (!snp_ready) @(negedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    while (!snp_done) @(negedge clk);
    h = snp_hit; d = snp_dirty; dat = snp_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, sd, memv, cached, d0, d1;
    logic          h, d;
    int            sc, brd, bwr, binv, pst, post;
    logic          hit, alloc;
    string         tg;
    for (int i = 0; i < 256; i++) bmem[i] = DW'(i * 7 + 16'h100);
    sc = 0;

    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 snp_ready", 32'(snp_ready), 1);
    check("R1 mem_valid", 32'(mem_valid), 0);
    check("R1 inv_valid", 32'(inv_valid), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    for (int a = 0; a < 4; a++) begin
      probe(1'b0, AW'(a), h, d, sd);
      check("R1 line invalid", 32'(h), 0);
    end

    // sweep: enable x attribute x direction x starting state
    for (int en = 0; en < 2; en++)
      for (int at = 0; at < 3; at++)
        for (int wr = 0; wr < 2; wr++)
          for (int pre = 0; pre < 3; pre++) begin
            sc++;
            d0 = DW'(16'hA000 + sc); d1 = DW'(16'hB000 + sc);
            do_reset();
            cache_en = 1'b1; shr = 1'b0;
            if (pre > 0) do_req(1'b0, 2'd2, AW'(sc * 5 + 3), '0, rd);
            if (pre == 2) do_req(1'b1, 2'd2, AW'(sc * 5 + 3), d0, rd);
            cached = (pre == 2) ? d0 : bmem[AW'(sc * 5 + 3)];
            memv = bmem[AW'(sc * 5 + 3)];
            pst = (pre == 0) ? 0 : (pre == 1 ? 2 : 3);  // 0 I, 1 S, 2 E, 3 M
            cache_en = en[0];
            brd = mrd; bwr = mwr; binv = ninv;
            do_req(wr[0], 2'(at), AW'(sc * 5 + 3), d1, rd);
            hit = (at != 0) && (pre != 0);
            alloc = (en == 1) && (at == 2);
            if (at == 0)      begin post = pst; tg = "R2"; end
            else if (hit)     begin post = (wr == 1) ? 3 : pst; tg = (wr == 1) ? "R7" : "R6"; end
            else if (alloc)   begin post = (wr == 1) ? 3 : 2; tg = (wr == 1) ? "R4" : "R3"; end
            else              begin post = 0; tg = "R5"; end
            if (wr == 0) check({tg, " rdata"}, 32'(rd), 32'((at != 0 && hit) ? cached : memv));
            check({tg, " mem reads"}, 32'(mrd - brd), 32'((wr == 0 && (at == 0 || !hit)) ? 1 : 0));
            check({tg, " mem writes"}, 32'(mwr - bwr), 32'((wr == 1 && (at == 0 || (!hit && !alloc))) ? 1 : 0));
            check({tg, " broadcasts"}, 32'(ninv - binv), 32'((wr == 1 && at != 0 && !hit && alloc) ? 1 : 0));
            probe(1'b0, AW'(sc * 5 + 3), h, d, sd);
            check((en == 0) ? "R12 snoop hit" : "R9 snoop hit", 32'(h), 32'(post != 0));
            check((en == 0) ? "R12 snoop dirty" : "R9 snoop dirty", 32'(d), 32'(post == 3));
            if (post == 3) check({tg, " line data"}, 32'(sd), 32'((at != 0 && wr == 1) ? d1 : d0));
          end

    // R3 shared fill then R7 upgrade with broadcast
    do_reset(); cache_en = 1'b1; shr = 1'b1;
    do_req(1'b0, 2'd2, 8'h41, '0, rd);
    check("R3 shared fill data", 32'(rd), 32'(bmem[8'h41]));
    shr = 1'b0; binv = ninv;
    do_req(1'b1, 2'd2, 8'h41, 16'h5A5A, rd);
    check("R7 shared write broadcasts", 32'(ninv - binv), 1);
    probe(1'b0, 8'h41, h, d, sd);
    check("R7 shared write dirty", 32'(d), 1);
    check("R7 shared write data", 32'(sd), 32'h5A5A);

    // R8 dirty victim evicted on conflict
    do_reset(); cache_en = 1'b1;
    do_req(1'b1, 2'd2, 8'h12, 16'hC0DE, rd);
    brd = mrd; bwr = mwr;
    do_req(1'b0, 2'd2, 8'h36, '0, rd);
    check("R8 victim written back", 32'(bmem[8'h12]), 32'hC0DE);
    check("R8 write count", 32'(mwr - bwr), 1);
    check("R8 fill data", 32'(rd), 32'(bmem[8'h36]));
    probe(1'b0, 8'h12, h, d, sd);
    check("R8 old tag gone", 32'(h), 0);

    // R9 exclusive to shared by read snoop, proven by later broadcast
    do_reset(); cache_en = 1'b1;
    do_req(1'b0, 2'd2, 8'h55, '0, rd);
    probe(1'b0, 8'h55, h, d, sd);
    check("R9 clean hit data", 32'(sd), 32'(bmem[8'h55]));
    binv = ninv;
    do_req(1'b1, 2'd2, 8'h55, 16'h1111, rd);
    check("R9 exclusive demoted to shared", 32'(ninv - binv), 1);

    // R10 invalidating snoops on dirty and clean lines
    do_reset(); cache_en = 1'b0;
    cache_en = 1'b1;
    do_req(1'b1, 2'd2, 8'h63, 16'h7E57, rd);
    cache_en = 1'b0; bwr = mwr;
    probe(1'b1, 8'h63, h, d, sd);
    check("R10 dirty supplied", 32'(sd), 32'h7E57);
    check("R10 dirty written back", 32'(bmem[8'h63]), 32'h7E57);
    probe(1'b0, 8'h63, h, d, sd);
    check("R10 dirty line invalid", 32'(h), 0);
    cache_en = 1'b1;
    do_req(1'b0, 2'd2, 8'h70, '0, rd);
    bwr = mwr;
    probe(1'b1, 8'h70, h, d, sd);
    check("R10 clean no write", 32'(mwr - bwr), 0);
    probe(1'b0, 8'h70, h, d, sd);
    check("R10 clean line invalid", 32'(h), 0);

    // R11 enable changed while a fill is in flight
    for (int flip = 0; flip < 2; flip++) begin
      do_reset(); cache_en = (flip == 0);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_attr = 2'd2; req_addr = 8'h2A;
      @(negedge clk);
      req_valid = 1'b0; cache_en = (flip != 0);
      while (!rsp_valid) @(negedge clk);
      check("R11 in-flight data", 32'(rsp_rdata), 32'(bmem[8'h2A]));
      probe(1'b0, 8'h2A, h, d, sd);
      check("R11 allocation follows accepted level", 32'(h), 32'(flip == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule